// File: doc/BRIEF.md
# Packet-Addressed Dual-Port Memory Tile

This tile is a storage element for a coarse-grained compute array. It keeps 512 words of 24 bits. It has no conventional address and data bus: every access arrives or leaves as a packet on a valid/ready channel. A word packet taken on the read-address channel selects a location, and the tile answers with exactly one packet on its output channel that carries the stored word. A write needs two separate packets, one on the write-address channel and one on the write-data channel. Each packet waits in its own one-entry slot. The memory is updated in the cycle after both slots hold a packet.

A configuration input turns the same storage into a first-in first-out queue. In that mode the tile keeps its own write and read pointers and an occupancy count. Packets on the write-data channel are pushed. Packets on either address channel are taken and dropped. Stored words leave on the output channel in arrival order. The configuration input may only change while reset is held.

Top module: `pktmem_tile`

## Requirements
- R1: After a synchronous reset `out_valid` is 0, and `wr_addr_ready`, `wr_data_ready` and `rd_addr_ready` are 1.
- R2: In memory mode, a write takes place once both the write-address slot and the write-data slot are filled, whichever arrives first. The word is stored in the cycle after the later of the two packets is taken.
- R3: In memory mode, a write slot's ready is 0 from the cycle after it takes a packet until the cycle after the write that empties it.
- R4: In memory mode, each read-address packet taken produces exactly one output packet, valid in the next cycle, that carries the word stored at that address.
- R5: Only bits 8:0 of an address packet select a location. Bits 23:9 have no effect on reads or writes.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` stays unchanged. In memory mode, `rd_addr_ready` equals `!out_valid || out_ready`, so no response is ever lost.
- R7: A read and a write to the same location in the same cycle both take place, and the read returns the word held before the write.
- R8: In queue mode, words taken on the write-data channel leave on the output channel in the order they arrived. Packets on `wr_addr` and `rd_addr` are always taken (ready is 1) and have no effect.
- R9: In queue mode, `wr_data_ready` is 0 while 512 words are held, and `out_valid` is 0 while the queue is empty. The occupancy never exceeds 512.
- R10: Reset empties the write slots, the output packet, the queue pointers and the occupancy count, and leaves the stored words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_fifo | input | 1 | 1 selects queue mode, 0 selects memory mode |
| rd_addr_valid | input | 1 | Read-address packet present |
| rd_addr_ready | output | 1 | Tile can take a read-address packet |
| rd_addr_data | input | 24 | Read-address packet |
| wr_addr_valid | input | 1 | Write-address packet present |
| wr_addr_ready | output | 1 | Tile can take a write-address packet |
| wr_addr_data | input | 24 | Write-address packet |
| wr_data_valid | input | 1 | Write-data packet present |
| wr_data_ready | output | 1 | Tile can take a write-data packet |
| wr_data_data | input | 24 | Write-data packet |
| out_valid | output | 1 | Output data packet present |
| out_ready | input | 1 | Consumer takes the output packet |
| out_data | output | 24 | Output data packet |

## Verification
Memory mode is first driven with directed sequences. These send the address packet before the data packet, the data packet first, and both in the same cycle, so that any dependence of the write on arrival order shows up. Addresses with random upper bits are confined to a few locations, so that writes and reads collide often. A read aimed at the cycle of a pending write separates read-first from write-first behaviour. Random stalls on the output check that responses are held and none is lost. Queue mode is filled to its limit with the output stalled, then drained, which shows the full boundary, the ordering and the empty condition, while stray address packets show they have no effect. A reset between writes and reads shows that stored words survive it.

// File: rtl/pktmem_pkg.sv
package pktmem_pkg;
  parameter int unsigned PKT_W  = 24;
  parameter int unsigned WORDS  = 512;
  typedef enum logic { MODE_RAM = 1'b0, MODE_FIFO = 1'b1 } tile_mode_e;
endpackage

// File: rtl/pktmem_ram.sv
module pktmem_ram #(
  parameter int unsigned DW    = 24,
  parameter int unsigned DEPTH = 512,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] store [DEPTH];

  // Read-first: a read and write to one location in one cycle return the old word.
  always_ff @(posedge clk) begin
    if (re) rdata <= store[raddr];
    if (we) store[waddr] <= wdata;
  end
endmodule

// File: rtl/pktmem_slot.sv
module pktmem_slot #(
  parameter int unsigned W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         drain,
  output logic         full,
  output logic [W-1:0] held
);
  assign in_ready = !full;

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
    end else if (drain) begin
      full <= 1'b0;
    end else if (in_valid && !full) begin
      full <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid && !full) held <= in_data;
  end
endmodule

// File: rtl/pktmem_fifo_ctl.sv
module pktmem_fifo_ctl #(
  parameter int unsigned DEPTH = 512,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          fetch,
  input  logic          pop,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic [CW-1:0] occ,
  output logic          full,
  output logic          has_unread
);
  localparam logic [AW-1:0] LAST  = AW'(DEPTH - 1);
  localparam logic [CW-1:0] LIMIT = CW'(DEPTH);

  logic [CW-1:0] unread;

  assign full       = (occ == LIMIT);
  assign has_unread = (unread != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr   <= '0;
      rptr   <= '0;
      occ    <= '0;
      unread <= '0;
    end else begin
      if (push)  wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (fetch) rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      case ({push, pop})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
      case ({push, fetch})
        2'b10:   unread <= unread + 1'b1;
        2'b01:   unread <= unread - 1'b1;
        default: unread <= unread;
      endcase
    end
  end
endmodule

// File: rtl/pktmem_tile.sv
module pktmem_tile
  import pktmem_pkg::*;
#(
  parameter int unsigned DW    = PKT_W,
  parameter int unsigned DEPTH = WORDS,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_fifo,
  input  logic          rd_addr_valid,
  output logic          rd_addr_ready,
  input  logic [DW-1:0] rd_addr_data,
  input  logic          wr_addr_valid,
  output logic          wr_addr_ready,
  input  logic [DW-1:0] wr_addr_data,
  input  logic          wr_data_valid,
  output logic          wr_data_ready,
  input  logic [DW-1:0] wr_data_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  tile_mode_e mode;
  assign mode = cfg_fifo ? MODE_FIFO : MODE_RAM;

  logic          as_full, as_ready, ds_full, ds_ready;
  logic [AW-1:0] as_held;
  logic [DW-1:0] ds_held;
  logic          commit;

  assign commit = (mode == MODE_RAM) && as_full && ds_full;

  pktmem_slot #(.W(AW)) u_addr_slot (
    .clk(clk), .rst(rst),
    .in_valid(wr_addr_valid && (mode == MODE_RAM)),
    .in_ready(as_ready),
    .in_data(wr_addr_data[AW-1:0]),
    .drain(commit),
    .full(as_full),
    .held(as_held)
  );

  pktmem_slot #(.W(DW)) u_data_slot (
    .clk(clk), .rst(rst),
    .in_valid(wr_data_valid && (mode == MODE_RAM)),
    .in_ready(ds_ready),
    .in_data(wr_data_data),
    .drain(commit),
    .full(ds_full),
    .held(ds_held)
  );

  logic          q_full, q_unread, q_push, q_fetch, q_pop;
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] occ_w;
  logic          can_load, rd_fire, load;

  assign can_load = !out_valid || out_ready;
  assign q_push   = (mode == MODE_FIFO) && wr_data_valid && !q_full;
  assign q_fetch  = (mode == MODE_FIFO) && q_unread && can_load;
  assign q_pop    = (mode == MODE_FIFO) && out_valid && out_ready;
  assign rd_fire  = (mode == MODE_RAM) && rd_addr_valid && can_load;
  assign load     = rd_fire || q_fetch;

  pktmem_fifo_ctl #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst),
    .push(q_push), .fetch(q_fetch), .pop(q_pop),
    .wptr(wptr), .rptr(rptr), .occ(occ_w),
    .full(q_full), .has_unread(q_unread)
  );

  logic          mem_we;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic [DW-1:0] mem_wdata;

  always_comb begin
    if (mode == MODE_FIFO) begin
      mem_we    = q_push;
      mem_waddr = wptr;
      mem_wdata = wr_data_data;
      mem_raddr = rptr;
    end else begin
      mem_we    = commit;
      mem_waddr = as_held;
      mem_wdata = ds_held;
      mem_raddr = rd_addr_data[AW-1:0];
    end
  end

  pktmem_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
    .clk(clk),
    .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .re(load), .raddr(mem_raddr), .rdata(out_data)
  );

  always_ff @(posedge clk) begin
    if (rst)           out_valid <= 1'b0;
    else if (load)     out_valid <= 1'b1;
    else if (out_ready) out_valid <= 1'b0;
  end

  assign rd_addr_ready = (mode == MODE_FIFO) ? 1'b1 : can_load;
  assign wr_addr_ready = (mode == MODE_FIFO) ? 1'b1 : as_ready;
  assign wr_data_ready = (mode == MODE_FIFO) ? !q_full : ds_ready;
endmodule

// File: rtl/pktmem_tile_chk.sv
module pktmem_tile_chk #(
  parameter int unsigned DW    = 24,
  parameter int unsigned DEPTH = 512,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_fifo,
  input logic          rd_addr_valid,
  input logic          rd_addr_ready,
  input logic          wr_addr_valid,
  input logic          wr_addr_ready,
  input logic          wr_data_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic [CW-1:0] occ
);
  assert_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);

  assert_slot_block_R3: assert property (@(posedge clk) disable iff (rst)
    (!cfg_fifo && wr_addr_valid && wr_addr_ready) |=> (cfg_fifo || !wr_addr_ready));

  assert_read_resp_R4: assert property (@(posedge clk) disable iff (rst)
    (!cfg_fifo && rd_addr_valid && rd_addr_ready) |=> out_valid);

  assert_out_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_fifo_full_R9: assert property (@(posedge clk) disable iff (rst)
    (cfg_fifo && occ == CW'(DEPTH)) |-> !wr_data_ready);

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    occ <= CW'(DEPTH));
endmodule

bind pktmem_tile pktmem_tile_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .cfg_fifo(cfg_fifo),
  .rd_addr_valid(rd_addr_valid), .rd_addr_ready(rd_addr_ready),
  .wr_addr_valid(wr_addr_valid), .wr_addr_ready(wr_addr_ready),
  .wr_data_ready(wr_data_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .occ(occ_w)
);

// File: tb/pktmem_tile_test.sv
`timescale 1ns/1ps
module pktmem_tile_test;
  localparam int DEPTH = 512;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst, cfg_fifo;
  logic        rd_addr_valid, wr_addr_valid, wr_data_valid, out_ready;
  logic [23:0] rd_addr_data, wr_addr_data, wr_data_data;
  logic        rd_addr_ready, wr_addr_ready, wr_data_ready, out_valid;
  logic [23:0] out_data;

  pktmem_tile uut (
    .clk(clk), .rst(rst), .cfg_fifo(cfg_fifo),
    .rd_addr_valid(rd_addr_valid), .rd_addr_ready(rd_addr_ready), .rd_addr_data(rd_addr_data),
    .wr_addr_valid(wr_addr_valid), .wr_addr_ready(wr_addr_ready), .wr_addr_data(wr_addr_data),
    .wr_data_valid(wr_data_valid), .wr_data_ready(wr_data_ready), .wr_data_data(wr_data_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  int    checks = 0, errors = 0;
  bit    done = 0;
  string req = "R1";

  // Behavioural reference state
  int mem   [DEPTH];
  bit known [DEPTH];
  bit m_as_v, m_ds_v, m_ov, m_okn;
  int m_as, m_ds, m_od, occ;
  int pend[$];

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_as_v = 0; m_ds_v = 0; m_ov = 0; occ = 0;
    pend.delete();
  endtask

  task automatic model_edge();
    bit can, rdf, push, pop;
    int rv; bit rk;
    bit old_as, old_ds;
    if (rst) begin model_reset(); return; end
    can = !m_ov || out_ready;
    pop = m_ov && out_ready;
    if (cfg_fifo) begin
      push = wr_data_valid && (occ != DEPTH);
      if (pend.size() > 0 && can) begin
        m_od = pend.pop_front(); m_ov = 1; m_okn = 1;
      end else if (pop) m_ov = 0;
      if (push) pend.push_back(int'(wr_data_data));
      occ = occ + int'(push) - int'(pop);
    end else begin
      rdf = rd_addr_valid && can;
      rv  = mem[rd_addr_data % DEPTH];
      rk  = known[rd_addr_data % DEPTH];
      old_as = m_as_v; old_ds = m_ds_v;
      if (old_as && old_ds) begin
        mem[m_as] = m_ds; known[m_as] = 1;
        m_as_v = 0; m_ds_v = 0;
      end
      if (wr_addr_valid && !old_as) begin m_as_v = 1; m_as = int'(wr_addr_data % DEPTH); end
      if (wr_data_valid && !old_ds) begin m_ds_v = 1; m_ds = int'(wr_data_data); end
      if (rdf) begin m_ov = 1; m_od = rv; m_okn = rk; end
      else if (pop) m_ov = 0;
    end
  endtask

  // Inputs are driven at the falling edge, compared 1 ns later, model advanced at the rising edge.
  task automatic step(input bit ra_v, input int ra, input bit wa_v, input int wa,
                      input bit wd_v, input int wd, input bit o_r);
    bit e_wa, e_wd, e_ra;
    @(negedge clk);
    rd_addr_valid = ra_v; rd_addr_data = 24'(ra);
    wr_addr_valid = wa_v; wr_addr_data = 24'(wa);
    wr_data_valid = wd_v; wr_data_data = 24'(wd);
    out_ready = o_r;
    #1;
    if (!rst) begin
      e_wa = cfg_fifo ? 1'b1 : !m_as_v;
      e_wd = cfg_fifo ? (occ != DEPTH) : !m_ds_v;
      e_ra = cfg_fifo ? 1'b1 : (!m_ov || o_r);
      chk(wr_addr_ready == e_wa, "wr_addr_ready", int'(wr_addr_ready), int'(e_wa));
      chk(wr_data_ready == e_wd, "wr_data_ready", int'(wr_data_ready), int'(e_wd));
      chk(rd_addr_ready == e_ra, "rd_addr_ready", int'(rd_addr_ready), int'(e_ra));
      chk(out_valid == m_ov, "out_valid", int'(out_valid), int'(m_ov));
      if (m_ov && m_okn)
        chk(int'(out_data) == m_od, "out_data", int'(out_data), m_od);
    end
    @(posedge clk);
    model_edge();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 1);
  endtask

  task automatic do_reset(input bit fifo);
    rst = 1; cfg_fifo = fifo;
    idle(2);
    rst = 0;
  endtask

  initial begin
    rst = 1; cfg_fifo = 0;
    rd_addr_valid = 0; wr_addr_valid = 0; wr_data_valid = 0; out_ready = 1;
    rd_addr_data = 0; wr_addr_data = 0; wr_data_data = 0;
    model_reset();
    idle(3);
    rst = 0;
    // R1: reset state is compared in the first idle cycles
    req = "R1"; idle(2);

    // R2: address first, data later; then data first; then both together
    req = "R2";
    step(0, 0, 1, 10, 0, 0, 1); idle(2);
    step(0, 0, 0, 0, 1, 24'hA5A5A5, 1); idle(2);
    step(0, 0, 0, 0, 1, 24'h123456, 1); idle(1);
    step(0, 0, 1, 11, 0, 0, 1); idle(2);
    step(0, 0, 1, 12, 1, 24'h0F0F0F, 1); idle(2);
    req = "R4";
    step(1, 10, 0, 0, 0, 0, 1);
    step(1, 11, 0, 0, 0, 0, 1);
    step(1, 12, 0, 0, 0, 0, 1); idle(2);

    // R3: a second address packet is held off while the slot waits for data
    req = "R3";
    step(0, 0, 1, 20, 0, 0, 1);
    step(0, 0, 1, 21, 0, 0, 1);
    step(0, 0, 1, 21, 0, 0, 1);
    step(0, 0, 1, 21, 1, 24'h00BEEF, 1);
    step(0, 0, 1, 21, 1, 24'h00CAFE, 1);
    step(0, 0, 1, 21, 1, 24'h00CAFE, 1);
    idle(3);
    step(1, 20, 0, 0, 0, 0, 1);
    step(1, 21, 0, 0, 0, 0, 1); idle(2);

    // R5: upper address bits ignored
    req = "R5";
    step(0, 0, 1, 24'hFFFE00 | 5, 1, 24'h777001, 1); idle(2);
    step(1, 24'h001A00 | 5, 0, 0, 0, 0, 1);
    step(1, 5, 0, 0, 0, 0, 1); idle(2);

    // R6: output stalled, data held, read input blocked
    req = "R6";
    step(1, 10, 0, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) step(1, 11, 0, 0, 0, 0, 0);
    step(1, 11, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 1); idle(2);

    // R7: read issued in the cycle the pending write lands
    req = "R7";
    step(0, 0, 1, 5, 1, 24'h999999, 1);
    step(1, 5, 0, 0, 0, 0, 1);
    step(1, 5, 0, 0, 0, 0, 1); idle(2);

    // R2/R4/R6/R7: random traffic on a few locations
    req = "R4";
    for (int i = 0; i < 3000; i++)
      step($urandom_range(0, 1), int'($urandom & 32'hFFFE07), $urandom_range(0, 1),
           int'($urandom & 32'hFFFE07), $urandom_range(0, 1), int'($urandom & 32'hFFFFFF),
           $urandom_range(0, 3) != 0);
    idle(4);

    // R10: stored words survive reset; pending slots are discarded
    req = "R10";
    step(0, 0, 1, 40, 1, 24'h400040, 1); idle(2);
    step(0, 0, 1, 41, 0, 0, 1);
    do_reset(0);
    idle(1);
    step(1, 40, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 1); idle(2);

    // R8/R9: queue mode, stray address packets, fill past capacity with output stalled
    for (int i = 0; i < DEPTH; i++) known[i] = 0;
    do_reset(1);
    req = "R9"; idle(2);
    req = "R8";
    for (int i = 0; i < DEPTH + 8; i++)
      step($urandom_range(0, 1), int'($urandom & 32'hFFFFFF), 1, int'($urandom & 32'hFFFFFF),
           1, int'($urandom & 32'hFFFFFF), 0);
    req = "R9";
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 1, 24'h111111, 0);
    req = "R8";
    for (int i = 0; i < DEPTH + 8; i++) step(0, 0, 1, 3, 0, 0, 1);
    req = "R9"; idle(3);
    req = "R8";
    for (int i = 0; i < 3000; i++)
      step($urandom_range(0, 1), int'($urandom & 32'hFFFFFF), $urandom_range(0, 1),
           int'($urandom & 32'hFFFFFF), $urandom_range(0, 3) != 0,
           int'($urandom & 32'hFFFFFF), $urandom_range(0, 2) != 0);
    for (int i = 0; i < DEPTH + 8; i++) step(0, 0, 0, 0, 0, 0, 1);
    // R10: reset empties the queue
    req = "R10";
    for (int i = 0; i < 20; i++) step(0, 0, 0, 0, 1, i, 0);
    do_reset(1);
    idle(3);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R0 watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule